// File: doc/BRIEF.md
# HALT and SLEEP Power Mode Controller

This block manages the low-power modes of a small microcontroller core. The instruction decoder raises a halt or a sleep request. The controller then drops the CPU clock enable, and in SLEEP it also drops the oscillator enable. It watches three wake sources: the pending interrupt request, the per-pin input-port wake events qualified by their enable masks, and the external reset pin.

HALT keeps the oscillator running and ends on any interrupt request. SLEEP stops the oscillator and ends only on an enabled input-pin event or on the reset pin. Every exit from SLEEP passes through a counted stabilization wait with the oscillator on and the CPU held. During that wait the controller measures how long the reset pin stays high. A short pulse is turned into a one-cycle wake interrupt, which is handed to the input-port service path. A pulse that reaches the long-pulse limit drives the internal system reset instead.

A sleep request made while every pin mask is clear would leave the part unable to wake. Such a request is refused, and a sticky status bit records it.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After the synchronous reset `rst`, the block reports RUN. In that state `cpu_run_o`=1, `osc_en_o`=1, `sys_rst_o`=0, `pin_wake_irq_o`=0 and `sleep_misuse_o`=0.
- R2: A halt request in RUN moves to HALT on the next clock, with `cpu_run_o`=0 and `osc_en_o`=1. HALT is held until `irq_i` is high, and the block returns to RUN on the clock after that.
- R3: A sleep request in RUN with at least one bit of `key_mask_i` set moves to SLEEP on the next clock, with `cpu_run_o`=0 and `osc_en_o`=0.
- R4: A sleep request in RUN while `key_mask_i` is all zero is ignored, so the block stays in RUN. It also sets `sleep_misuse_o`, which stays set until `rst`.
- R5: In SLEEP, `irq_i` and wake events on pins whose mask bit is 0 have no effect, and the block stays in SLEEP.
- R6: In SLEEP, a wake event on a pin whose mask bit is 1 moves to STABILIZE on the next clock. STABILIZE lasts exactly STAB_CYCLES cycles with `osc_en_o`=1 and `cpu_run_o`=0. The block then enters RUN without a wake interrupt pulse.
- R7: In SLEEP, a reset-pin pulse that is high for w clock samples, with w no greater than RST_LONG, moves to STABILIZE. STABILIZE then lasts max(STAB_CYCLES, w) cycles, and the block enters RUN. `pin_wake_irq_o` is high for exactly the first RUN cycle.
- R8: In SLEEP, a reset-pin pulse of w greater than RST_LONG samples leaves STABILIZE after RST_LONG cycles and enters RESET. In RESET, `sys_rst_o`=1, `osc_en_o`=1 and `cpu_run_o`=0. The block returns to RUN on the clock after the pin is seen low, without a wake interrupt pulse.
- R9: The reset pin seen high in RUN or HALT moves to RESET on the next clock.
- R10: Each clock takes at most one mode transition. In RUN the reset pin has priority over a sleep request, and a sleep request has priority over a halt request.
- R11: `mode_o` encodes RUN=0, HALT=1, SLEEP=2, STABILIZE=3, RESET=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock; counts oscillator cycles once restarted |
| rst | input | 1 | Synchronous active-high reset of the controller |
| halt_req_i | input | 1 | Halt request from the instruction decoder |
| sleep_req_i | input | 1 | Sleep request from the instruction decoder |
| irq_i | input | 1 | Pending interrupt request (ends HALT) |
| key_evt_i | input | N_KEY | Per-pin input-port wake events |
| key_mask_i | input | N_KEY | Per-pin wake enable masks |
| rst_pin_i | input | 1 | External reset pin, synchronized |
| cpu_run_o | output | 1 | CPU clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| sys_rst_o | output | 1 | Internal system reset |
| pin_wake_irq_o | output | 1 | One-cycle input-port interrupt from a short reset pulse |
| sleep_misuse_o | output | 1 | Sticky flag for a refused sleep request |
| mode_o | output | 3 | Current power mode |

## Verification
The bench builds the controller with N_KEY=4, STAB_CYCLES=8 and RST_LONG=12. At these sizes every one of the sixteen mask values can be tried against a wake event on every pin. The reset-pin pulse width can also be swept from one sample to beyond the long-pulse limit, which covers both sides of the stabilization length and of the reset threshold. With these values the boundary widths w=STAB_CYCLES, w=RST_LONG and w=RST_LONG+1 are each only a few cycles long.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    PM_RUN    = 3'd0,
    PM_HALT   = 3'd1,
    PM_SLEEP  = 3'd2,
    PM_STAB   = 3'd3,
    PM_RESET  = 3'd4
  } pm_state_e;
endpackage

// File: rtl/pmc_sat_counter.sv
module pmc_sat_counter #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (inc && cnt_q != LAST)
      cnt_q <= cnt_q + 1'b1;
  end

  assign hit = (cnt_q == LAST);

  // counter saturates at its limit (supports R6, R8 cycle counts)
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  assert_cnt_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/pmc_wake_detect.sv
module pmc_wake_detect #(
  parameter int N_KEY = 4
) (
  input  logic [N_KEY-1:0] key_evt,
  input  logic [N_KEY-1:0] key_mask,
  output logic             key_hit,
  output logic             mask_any
);
  logic [N_KEY-1:0] qualified;

  for (genvar g = 0; g < N_KEY; g++) begin : g_pin
    assign qualified[g] = key_evt[g] & key_mask[g];
  end

  assign key_hit  = |qualified;
  assign mask_any = |key_mask;
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pwr_mode_pkg::*;
#(
  parameter int N_KEY       = 4,
  parameter int STAB_CYCLES = 512,
  parameter int RST_LONG    = 65
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt_req_i,
  input  logic             sleep_req_i,
  input  logic             irq_i,
  input  logic [N_KEY-1:0] key_evt_i,
  input  logic [N_KEY-1:0] key_mask_i,
  input  logic             rst_pin_i,
  output logic             cpu_run_o,
  output logic             osc_en_o,
  output logic             sys_rst_o,
  output logic             pin_wake_irq_o,
  output logic             sleep_misuse_o,
  output logic [2:0]       mode_o
);
  pm_state_e state_q, state_d;
  logic src_pin_q, src_pin_d;
  logic misuse_set;
  logic key_hit, mask_any;
  logic stab_done, pin_cnt_hit, long_hit;
  logic wake_pulse_d;

  pmc_wake_detect #(.N_KEY(N_KEY)) u_wake (
    .key_evt  (key_evt_i),
    .key_mask (key_mask_i),
    .key_hit  (key_hit),
    .mask_any (mask_any)
  );

  pmc_sat_counter #(.LIMIT(STAB_CYCLES)) u_stab_cnt (
    .clk (clk),
    .rst (rst),
    .clr (state_q != PM_STAB),
    .inc (1'b1),
    .hit (stab_done)
  );

  pmc_sat_counter #(.LIMIT(RST_LONG)) u_pulse_meter (
    .clk (clk),
    .rst (rst),
    .clr ((state_q != PM_STAB) || !rst_pin_i),
    .inc (1'b1),
    .hit (pin_cnt_hit)
  );

  assign long_hit = rst_pin_i && pin_cnt_hit;

  always_comb begin
    state_d    = state_q;
    src_pin_d  = src_pin_q;
    misuse_set = 1'b0;
    unique case (state_q)
      PM_RUN: begin
        if (rst_pin_i)
          state_d = PM_RESET;
        else if (sleep_req_i) begin
          if (mask_any) state_d = PM_SLEEP;
          else          misuse_set = 1'b1;
        end else if (halt_req_i)
          state_d = PM_HALT;
      end
      PM_HALT: begin
        if (rst_pin_i)  state_d = PM_RESET;
        else if (irq_i) state_d = PM_RUN;
      end
      PM_SLEEP: begin
        if (key_hit) begin
          state_d   = PM_STAB;
          src_pin_d = 1'b0;
        end else if (rst_pin_i) begin
          state_d   = PM_STAB;
          src_pin_d = 1'b1;
        end
      end
      PM_STAB: begin
        if (long_hit)
          state_d = PM_RESET;
        else if (stab_done && !(src_pin_q && rst_pin_i))
          state_d = PM_RUN;
      end
      PM_RESET: begin
        if (!rst_pin_i) state_d = PM_RUN;
      end
      default: state_d = PM_RUN;
    endcase
  end

  assign wake_pulse_d = (state_q == PM_STAB) && (state_d == PM_RUN) && src_pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= PM_RUN;
      src_pin_q      <= 1'b0;
      cpu_run_o      <= 1'b1;
      osc_en_o       <= 1'b1;
      sys_rst_o      <= 1'b0;
      pin_wake_irq_o <= 1'b0;
      sleep_misuse_o <= 1'b0;
    end else begin
      state_q        <= state_d;
      src_pin_q      <= src_pin_d;
      cpu_run_o      <= (state_d == PM_RUN);
      osc_en_o       <= (state_d != PM_SLEEP);
      sys_rst_o      <= (state_d == PM_RESET);
      pin_wake_irq_o <= wake_pulse_d;
      if (misuse_set) sleep_misuse_o <= 1'b1;
    end
  end

  assign mode_o = 3'(state_q);

  assert_halt_exit_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_HALT && irq_i && !rst_pin_i) |=> (state_q == PM_RUN && cpu_run_o));
  assert_sleep_gated_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_SLEEP) |-> (!osc_en_o && !cpu_run_o));
  assert_misuse_refused_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_RUN && sleep_req_i && key_mask_i == '0 && !rst_pin_i)
      |=> (state_q == PM_RUN && sleep_misuse_o));
  assert_sleep_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_SLEEP && !key_hit && !rst_pin_i) |=> (state_q == PM_SLEEP));
  assert_stab_osc_on_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_STAB) |-> (osc_en_o && !cpu_run_o));
  assert_irq_after_stab_R7: assert property (@(posedge clk) disable iff (rst)
    pin_wake_irq_o |-> (state_q == PM_RUN && $past(state_q) == PM_STAB));
  assert_reset_outputs_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_RESET) |-> (sys_rst_o && osc_en_o && !cpu_run_o));
  assert_pin_reset_R9: assert property (@(posedge clk) disable iff (rst)
    ((state_q == PM_RUN || state_q == PM_HALT) && rst_pin_i) |=> (state_q == PM_RESET));
endmodule

// File: tb/pwr_mode_ctl_tb.sv
module pwr_mode_ctl_tb_top;
  localparam int NK   = 4;
  localparam int STAB = 8;
  localparam int LONG = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_req = 0, sleep_req = 0, irq = 0, rst_pin = 0;
  logic [NK-1:0] key_evt = '0, key_mask = '0;
  logic cpu_run, osc_en, sys_rst, pin_irq, misuse;
  logic [2:0] mode;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  pwr_mode_ctl #(.N_KEY(NK), .STAB_CYCLES(STAB), .RST_LONG(LONG)) dut_i (
    .clk(clk), .rst(rst), .halt_req_i(halt_req), .sleep_req_i(sleep_req),
    .irq_i(irq), .key_evt_i(key_evt), .key_mask_i(key_mask), .rst_pin_i(rst_pin),
    .cpu_run_o(cpu_run), .osc_en_o(osc_en), .sys_rst_o(sys_rst),
    .pin_wake_irq_o(pin_irq), .sleep_misuse_o(misuse), .mode_o(mode)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; halt_req = 0; sleep_req = 0; irq = 0; rst_pin = 0;
    key_evt = '0; key_mask = '0;
    tick(); tick();
    rst = 1'b0;
    tick();
  endtask

  task automatic go_sleep(input logic [NK-1:0] m);
    key_mask = m; sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
  endtask

  // returns number of STABILIZE cycles observed; stops at first non-STAB mode
  task automatic count_stab(output int n);
    n = 0;
    while (mode == 3 && n < 200) begin
      n++;
      tick();
    end
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=0", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int exp_n;
    do_reset();
    // R1 reset state
    chk("R1", "mode", mode, 0);
    chk("R1", "cpu_run", cpu_run, 1);
    chk("R1", "osc_en", osc_en, 1);
    chk("R1", "sys_rst", sys_rst, 0);
    chk("R1", "pin_irq", pin_irq, 0);
    chk("R1", "misuse", misuse, 0);

    // R2 halt, exit after d cycles of waiting
    for (int d = 0; d < 4; d++) begin
      halt_req = 1; tick(); halt_req = 0;
      chk("R2", "halt mode", mode, 1);
      chk("R2", "halt cpu_run", cpu_run, 0);
      chk("R2", "halt osc_en", osc_en, 1);
      repeat (d) tick();
      chk("R2", "halt held", mode, 1);
      irq = 1; tick(); irq = 0;
      chk("R2", "halt exit", mode, 0);
      chk("R2", "halt exit cpu_run", cpu_run, 1);
    end

    // R4 sleep with no mask refused
    go_sleep('0);
    chk("R4", "mode stays run", mode, 0);
    chk("R4", "misuse set", misuse, 1);
    tick();
    chk("R4", "misuse sticky", misuse, 1);

    // R3 R5 R6: every mask against every pin
    for (int m = 1; m < (1 << NK); m++) begin
      for (int p = 0; p < NK; p++) begin
        int first_on;
        go_sleep(NK'(m));
        chk("R3", "sleep mode", mode, 2);
        chk("R3", "sleep osc_en", osc_en, 0);
        chk("R3", "sleep cpu_run", cpu_run, 0);
        key_evt = NK'(1 << p); irq = 1; tick(); key_evt = '0; irq = 0;
        if (((m >> p) & 1) == 0) begin
          chk("R5", "masked pin ignored", mode, 2);
          first_on = 0;
          for (int q = NK - 1; q >= 0; q--) if (((m >> q) & 1) == 1) first_on = q;
          key_evt = NK'(1 << first_on); tick(); key_evt = '0;
        end
        chk("R6", "stab entered", mode, 3);
        chk("R6", "stab osc_en", osc_en, 1);
        count_stab(n);
        chk("R6", "stab length", n, STAB);
        chk("R6", "back to run", mode, 0);
        chk("R6", "no pin irq", pin_irq, 0);
      end
    end

    // R7 R8 reset-pin width sweep during SLEEP
    for (int w = 1; w <= LONG + 3; w++) begin
      int cyc;
      int stabn;
      int saw_reset;
      int irq_at_run;
      go_sleep(NK'(1));
      rst_pin = 1; cyc = 0; stabn = 0; saw_reset = 0; irq_at_run = 0;
      while (cyc < 200) begin
        tick();
        cyc++;
        if (cyc == w) rst_pin = 0;
        if (mode == 3) stabn++;
        if (mode == 4) begin
          if (saw_reset == 0) begin
            chk("R8", "reset sys_rst", sys_rst, 1);
            chk("R8", "reset cpu_run", cpu_run, 0);
            chk("R8", "reset osc_en", osc_en, 1);
          end
          saw_reset = 1;
        end
        if (mode == 0) begin
          irq_at_run = pin_irq;
          break;
        end
      end
      rst_pin = 0;
      if (w <= LONG) begin
        exp_n = (w > STAB) ? w : STAB;
        chk("R7", "stab length", stabn, exp_n);
        chk("R7", "no reset", saw_reset, 0);
        chk("R7", "irq pulse", irq_at_run, 1);
        tick();
        chk("R7", "irq one cycle", pin_irq, 0);
      end else begin
        chk("R8", "stab length", stabn, LONG);
        chk("R8", "reset taken", saw_reset, 1);
        chk("R8", "no irq", irq_at_run, 0);
        chk("R8", "run after release", mode, 0);
      end
    end

    // R9 pin in RUN and HALT
    rst_pin = 1; tick();
    chk("R9", "run->reset", mode, 4);
    rst_pin = 0; tick();
    chk("R9", "reset->run", mode, 0);
    halt_req = 1; tick(); halt_req = 0;
    rst_pin = 1; irq = 1; tick(); rst_pin = 0; irq = 0;
    chk("R9", "halt->reset", mode, 4);
    tick();
    chk("R11", "run encoding", mode, 0);

    // R10 priority and single transition
    key_mask = NK'(2);
    rst_pin = 1; sleep_req = 1; halt_req = 1; tick();
    rst_pin = 0; sleep_req = 0; halt_req = 0;
    chk("R10", "pin beats sleep", mode, 4);
    tick();
    sleep_req = 1; halt_req = 1; tick(); sleep_req = 0; halt_req = 0;
    chk("R10", "sleep beats halt", mode, 2);
    key_evt = NK'(2); tick(); key_evt = '0;
    chk("R10", "one step to stab", mode, 3);
    count_stab(n);

    // R4 misuse cleared only by reset
    chk("R4", "misuse still set", misuse, 1);
    do_reset();
    chk("R1", "misuse cleared", misuse, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule